// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block gathers a parameterised set of interrupt lines, a multiple of 32, and decides which one a single processor should service next. Each line carries an enable flag, a pending flag, an in-service (active) flag, an 8-bit priority, an 8-bit processor target mask, a group flag and a 2-bit trigger setting. Inputs are sampled once per clock. Lines set to edge mode latch a pending flag on their asserting transition. Lines set to level mode report pending for as long as the input stays asserted.

Software reaches every per-line field through a 32-bit register port. Reads return data one cycle after the request. A global forwarding switch gates the output. When forwarding is on, the block offers the best candidate line to the processor side. A candidate is pending, enabled and not active. The best candidate has the smallest priority value; on a tie the lower line number wins. The processor accepts the offer with an acknowledge strobe, which marks the line active. It later retires the line with an end-of-interrupt strobe carrying the line number.

Top module: `intr_dist_bank`

## Requirements
- R1: Bit 0 of the word at byte offset 0x000 is the forwarding switch and reads back. While it is 0, `fwd_valid` is 0 one cycle later. While it is 1, the best candidate is offered.
- R2: The read-only word at 0x004 returns NUM_LINES/32-1 in bits 4:0 and zeros elsewhere.
- R3: Enable words sit at 0x100+4*(id>>5) (set) and 0x180+4*(id>>5) (clear), with bit id&31 per line. A 1 bit sets or clears that line's enable, and a 0 bit leaves it alone. Reading either word returns the current enables.
- R4: Pending words sit at 0x200+4*(id>>5) (write 1 sets) and 0x280+4*(id>>5) (write 1 clears). Reading either word returns the pending state, which combines latched pending with live level inputs.
- R5: Priority bytes sit at 0x400+4*(id>>2) and target bytes at 0x800+4*(id>>2), in bits 8*(id&3)+7:8*(id&3). Both read back.
- R6: Trigger settings sit at 0xC00+4*(id>>4), in bits 2*(id&15)+1:2*(id&15). Field bit 0 is polarity (1 high, 0 low). Field bit 1 is mode (1 edge, 0 level). The settings read back, and after reset every line is level, active-low.
- R7: An edge line becomes pending two cycles after its input makes the asserting transition. It stays pending after the input returns, until the line is cleared or acknowledged.
- R8: A level line reads pending exactly while its input is at the asserted polarity.
- R9: `fwd_id`, `fwd_prio` and `fwd_target` give the candidate with the lowest priority value, with ties going to the lowest line number. The choice updates one cycle after any state change.
- R10: `cpu_ack` while `fwd_valid` is high does three things: it sets the active bit of `fwd_id`, it clears that line's latched pending bit, and it forces `fwd_valid` low on the next cycle. An active line is never offered. Active bits read at 0x380+4*(id>>5).
- R11: `eoi_valid` clears the active bit of line `eoi_id`. Writing 1 to a bit at 0x380+4*(id>>5) also clears that active bit.
- R12: Group bits sit at 0x080+4*(id>>5), one per line. They read back and do not affect the choice of line.
- R13: An address with bits 1:0 not zero, an address no register occupies, or a word index beyond NUM_LINES reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data valid next cycle |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| irq_in | input | NUM_LINES | Raw interrupt inputs |
| cpu_ack | input | 1 | Processor accepts the offered line |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 10 | Line being retired |
| fwd_valid | output | 1 | A line is offered |
| fwd_id | output | 10 | Offered line number |
| fwd_prio | output | 8 | Priority of offered line |
| fwd_target | output | 8 | Target mask of offered line |

## Verification
The hardest case to reach is a line that is pending but active, because that needs a full offer and acknowledge round first. The stimulus sets a line pending and lets it be offered, then acknowledges it. It then re-arms the pending bit through the register port and confirms no offer appears until the end-of-interrupt strobe. Priority ties, priority overtakes and disabling the current winner are all driven through the register port. An edge line is walked through low, high and low again to show that its latch holds.

// File: rtl/intr_dist_pkg.sv
package intr_dist_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int PRIO_W = 8;
    localparam int TGT_W  = 8;
    localparam int ID_W   = 10;

    typedef enum logic [3:0] {
        RK_CTRL, RK_TYPE, RK_GROUP, RK_ENSET, RK_ENCLR,
        RK_PSET, RK_PCLR, RK_ACT, RK_PRIO, RK_TGT, RK_CFG, RK_NONE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] idx;
    } reg_sel_t;

    typedef struct packed {
        logic              valid;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
        logic [TGT_W-1:0]  tgt;
    } fwd_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.kind = RK_NONE;
        s.idx  = 8'd0;
        if (a[1:0] == 2'b00) begin
            case (a[11:10])
                2'b01: begin s.kind = RK_PRIO; s.idx = a[9:2]; end
                2'b10: begin s.kind = RK_TGT;  s.idx = a[9:2]; end
                2'b11: begin
                    if (a[9:8] == 2'b00) begin
                        s.kind = RK_CFG;
                        s.idx  = {2'b00, a[7:2]};
                    end
                end
                default: begin
                    s.idx = {3'b000, a[6:2]};
                    case (a[9:7])
                        3'b000: begin
                            if (a[6:2] == 5'd0)      s.kind = RK_CTRL;
                            else if (a[6:2] == 5'd1) s.kind = RK_TYPE;
                        end
                        3'b001: s.kind = RK_GROUP;
                        3'b010: s.kind = RK_ENSET;
                        3'b011: s.kind = RK_ENCLR;
                        3'b100: s.kind = RK_PSET;
                        3'b101: s.kind = RK_PCLR;
                        3'b111: s.kind = RK_ACT;
                        default: s.kind = RK_NONE;
                    endcase
                end
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/intr_line_word.sv
module intr_line_word #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] irq_lvl,
    input  logic [W-1:0] pol_high,
    input  logic [W-1:0] edge_mode,
    input  logic [W-1:0] en_set,
    input  logic [W-1:0] en_clr,
    input  logic [W-1:0] pend_set,
    input  logic [W-1:0] pend_clr,
    input  logic [W-1:0] ack_hit,
    input  logic [W-1:0] act_clr,
    output logic [W-1:0] enable,
    output logic [W-1:0] pending,
    output logic [W-1:0] active
);
    logic [W-1:0] en_q, pend_q, act_q, prev_q;
    logic [W-1:0] asserted, was_asserted, edge_hit;

    assign asserted     = ~(irq_lvl ^ pol_high);
    assign was_asserted = ~(prev_q ^ pol_high);
    assign edge_hit     = edge_mode & asserted & ~was_asserted;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
            act_q  <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= irq_lvl;
            en_q   <= (en_q | en_set) & ~en_clr;
            pend_q <= (pend_q | pend_set | edge_hit) & ~(pend_clr | ack_hit);
            act_q  <= (act_q | ack_hit) & ~act_clr;
        end
    end

    assign enable  = en_q;
    assign pending = pend_q | (~edge_mode & asserted);
    assign active  = act_q;

    assert_en_set_R3: assert property (@(posedge clk) disable iff (rst)
        ((en_set & ~en_clr) != '0) |=> ((en_q & $past(en_set & ~en_clr)) == $past(en_set & ~en_clr)));

    assert_en_clr_R3: assert property (@(posedge clk) disable iff (rst)
        (en_clr != '0) |=> ((en_q & $past(en_clr)) == '0));

    assert_edge_latch_R7: assert property (@(posedge clk) disable iff (rst)
        ((edge_hit & ~(pend_clr | ack_hit)) != '0)
        |=> ((pend_q & $past(edge_hit & ~(pend_clr | ack_hit))) == $past(edge_hit & ~(pend_clr | ack_hit))));

endmodule

// File: rtl/intr_prio_select.sv
module intr_prio_select
    import intr_dist_pkg::*;
#(
    parameter int N = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        cand,
    input  logic [N*PRIO_W-1:0] prio_flat,
    output logic                found,
    output logic [ID_W-1:0]     sel_id,
    output logic [PRIO_W-1:0]   sel_prio
);
    localparam int IDX_W = $clog2(N);

    logic              best_f;
    logic [PRIO_W-1:0] best_p;
    logic [IDX_W-1:0]  best_i;

    always_comb begin
        best_f = 1'b0;
        best_p = '1;
        best_i = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!best_f || prio_flat[PRIO_W*i +: PRIO_W] < best_p)) begin
                best_f = 1'b1;
                best_p = prio_flat[PRIO_W*i +: PRIO_W];
                best_i = IDX_W'(i);
            end
        end
    end

    assign found    = best_f;
    assign sel_id   = ID_W'(best_i);
    assign sel_prio = best_p;

    assert_pick_is_cand_R9: assert property (@(posedge clk) disable iff (rst)
        found |-> cand[sel_id[IDX_W-1:0]]);

endmodule

// File: rtl/intr_dist_bank.sv
module intr_dist_bank
    import intr_dist_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 cpu_ack,
    input  logic                 eoi_valid,
    input  logic [ID_W-1:0]      eoi_id,
    output logic                 fwd_valid,
    output logic [ID_W-1:0]      fwd_id,
    output logic [PRIO_W-1:0]    fwd_prio,
    output logic [TGT_W-1:0]     fwd_target
);
    localparam int NWORDS  = NUM_LINES / 32;
    localparam int LINES_W = NUM_LINES / 4;
    localparam int CFG_W   = NUM_LINES / 16;
    localparam logic [4:0] TYPE_N = 5'(NWORDS - 1);

    reg_sel_t sel;
    assign sel = decode_addr(reg_addr);

    logic                 ctrl_en;
    logic [PRIO_W-1:0]    prio_q [NUM_LINES];
    logic [TGT_W-1:0]     tgt_q  [NUM_LINES];
    logic [1:0]           cfg_q  [NUM_LINES];
    logic [NUM_LINES-1:0] group_q;
    logic [NUM_LINES-1:0] irq_s;
    fwd_t                 fwd_q;
    logic [DATA_W-1:0]    rd_word, rdata_q;

    // byte-lane and packed-field configuration storage
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en <= 1'b0;
            group_q <= '0;
            for (int i = 0; i < NUM_LINES; i++) begin
                prio_q[i] <= '0;
                tgt_q[i]  <= '0;
                cfg_q[i]  <= 2'b00;
            end
        end else if (reg_wr) begin
            if (sel.kind == RK_CTRL) ctrl_en <= reg_wdata[0];
            for (int w = 0; w < NWORDS; w++)
                if (sel.kind == RK_GROUP && int'(sel.idx) == w)
                    group_q[32*w +: 32] <= reg_wdata;
            for (int i = 0; i < NUM_LINES; i++) begin
                if (sel.kind == RK_PRIO && int'(sel.idx) == i / 4)
                    prio_q[i] <= reg_wdata[8*(i%4) +: 8];
                if (sel.kind == RK_TGT && int'(sel.idx) == i / 4)
                    tgt_q[i] <= reg_wdata[8*(i%4) +: 8];
                if (sel.kind == RK_CFG && int'(sel.idx) == i / 16)
                    cfg_q[i] <= reg_wdata[2*(i%16) +: 2];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_s <= '0;
        else     irq_s <= irq_in;
    end

    // per-line command masks
    logic [NUM_LINES-1:0] en_set_m, en_clr_m, p_set_m, p_clr_m, a_clr_m;
    logic [NUM_LINES-1:0] ack_m, eoi_m, pol_v, edge_v;
    logic                 ack_take;

    assign ack_take = cpu_ack && fwd_q.valid;

    always_comb begin
        en_set_m = '0; en_clr_m = '0; p_set_m = '0; p_clr_m = '0; a_clr_m = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (reg_wr && int'(sel.idx) == w) begin
                case (sel.kind)
                    RK_ENSET: en_set_m[32*w +: 32] = reg_wdata;
                    RK_ENCLR: en_clr_m[32*w +: 32] = reg_wdata;
                    RK_PSET:  p_set_m[32*w +: 32]  = reg_wdata;
                    RK_PCLR:  p_clr_m[32*w +: 32]  = reg_wdata;
                    RK_ACT:   a_clr_m[32*w +: 32]  = reg_wdata;
                    default: ;
                endcase
            end
        end
        for (int i = 0; i < NUM_LINES; i++) begin
            ack_m[i]  = ack_take && (int'(fwd_q.id) == i);
            eoi_m[i]  = eoi_valid && (int'(eoi_id) == i);
            pol_v[i]  = cfg_q[i][0];
            edge_v[i] = cfg_q[i][1];
        end
    end

    logic [NUM_LINES-1:0] en_v, pend_v, act_v;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        intr_line_word #(.W(32)) u_word (
            .clk       (clk),
            .rst       (rst),
            .irq_lvl   (irq_s[32*w +: 32]),
            .pol_high  (pol_v[32*w +: 32]),
            .edge_mode (edge_v[32*w +: 32]),
            .en_set    (en_set_m[32*w +: 32]),
            .en_clr    (en_clr_m[32*w +: 32]),
            .pend_set  (p_set_m[32*w +: 32]),
            .pend_clr  (p_clr_m[32*w +: 32]),
            .ack_hit   (ack_m[32*w +: 32]),
            .act_clr   (a_clr_m[32*w +: 32] | eoi_m[32*w +: 32]),
            .enable    (en_v[32*w +: 32]),
            .pending   (pend_v[32*w +: 32]),
            .active    (act_v[32*w +: 32])
        );
    end

    // candidate selection
    logic [NUM_LINES*PRIO_W-1:0] prio_flat;
    logic                        sel_found;
    logic [ID_W-1:0]             sel_id;
    logic [PRIO_W-1:0]           sel_prio;
    logic [TGT_W-1:0]            sel_tgt;

    always_comb begin
        sel_tgt = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            prio_flat[PRIO_W*i +: PRIO_W] = prio_q[i];
            if (int'(sel_id) == i) sel_tgt = tgt_q[i];
        end
    end

    intr_prio_select #(.N(NUM_LINES)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .cand      (pend_v & en_v & ~act_v),
        .prio_flat (prio_flat),
        .found     (sel_found),
        .sel_id    (sel_id),
        .sel_prio  (sel_prio)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_q <= '0;
        end else begin
            fwd_q.valid <= ctrl_en && sel_found && !ack_take;
            fwd_q.id    <= sel_id;
            fwd_q.prio  <= sel_prio;
            fwd_q.tgt   <= sel_tgt;
        end
    end

    // read path
    always_comb begin
        rd_word = '0;
        case (sel.kind)
            RK_CTRL: rd_word = {31'd0, ctrl_en};
            RK_TYPE: rd_word = {27'd0, TYPE_N};
            default: ;
        endcase
        for (int w = 0; w < NWORDS; w++) begin
            if (int'(sel.idx) == w) begin
                case (sel.kind)
                    RK_GROUP:           rd_word = group_q[32*w +: 32];
                    RK_ENSET, RK_ENCLR: rd_word = en_v[32*w +: 32];
                    RK_PSET, RK_PCLR:   rd_word = pend_v[32*w +: 32];
                    RK_ACT:             rd_word = act_v[32*w +: 32];
                    default: ;
                endcase
            end
        end
        for (int i = 0; i < NUM_LINES; i++) begin
            if (sel.kind == RK_PRIO && int'(sel.idx) == i / 4) rd_word[8*(i%4) +: 8] = prio_q[i];
            if (sel.kind == RK_TGT  && int'(sel.idx) == i / 4) rd_word[8*(i%4) +: 8] = tgt_q[i];
            if (sel.kind == RK_CFG  && int'(sel.idx) == i / 16) rd_word[2*(i%16) +: 2] = cfg_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (reg_rd) rdata_q <= rd_word;
    end

    assign reg_rdata  = rdata_q;
    assign fwd_valid  = fwd_q.valid;
    assign fwd_id     = fwd_q.id;
    assign fwd_prio   = fwd_q.prio;
    assign fwd_target = fwd_q.tgt;

    assert_fwd_gate_R1: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |=> !fwd_valid);

    assert_ack_drops_R10: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && fwd_valid) |=> !fwd_valid);

    assert_ack_marks_R10: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && fwd_valid && !eoi_valid && !reg_wr)
        |=> ((act_v & $past(ack_m)) == $past(ack_m)));

    assert_eoi_clears_R11: assert property (@(posedge clk) disable iff (rst)
        eoi_valid |=> ((act_v & $past(eoi_m)) == '0));

    assert_no_active_offer_R10: assert property (@(posedge clk) disable iff (rst)
        (fwd_valid && !$past(ack_take)) |-> ((ack_m & act_v) == '0));

endmodule

// File: tb/tb_intr_dist_bank.sv
`timescale 1ns/1ps
module tb_intr_dist_bank;
    localparam int NL = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr, reg_rd;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [NL-1:0] irq_in;
    logic        cpu_ack, eoi_valid;
    logic [9:0]  eoi_id, fwd_id;
    logic        fwd_valid;
    logic [7:0]  fwd_prio, fwd_target;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    intr_dist_bank #(.NUM_LINES(NL)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_in(irq_in), .cpu_ack(cpu_ack), .eoi_valid(eoi_valid),
        .eoi_id(eoi_id), .fwd_valid(fwd_valid), .fwd_id(fwd_id),
        .fwd_prio(fwd_prio), .fwd_target(fwd_target)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        chk(req, reg_rdata, exp);
    endtask

    task automatic fwd_chk(input string req, input logic v, input logic [9:0] id,
                           input logic [7:0] p, input logic [7:0] t);
        chk({req, " valid"}, 32'(fwd_valid), 32'(v));
        if (v) begin
            chk({req, " id"}, 32'(fwd_id), 32'(id));
            chk({req, " prio"}, 32'(fwd_prio), 32'(p));
            chk({req, " target"}, 32'(fwd_target), 32'(t));
        end
    endtask

    task automatic pulse_ack();
        @(negedge clk); cpu_ack = 1'b1;
        @(negedge clk); cpu_ack = 1'b0;
    endtask

    task automatic pulse_eoi(input logic [9:0] id);
        @(negedge clk); eoi_valid = 1'b1; eoi_id = id;
        @(negedge clk); eoi_valid = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R1 ctrl reset", 12'h000, 32'h0);
        rd_chk("R2 type", 12'h004, 32'h1);
        rd_chk("R3 enable reset", 12'h100, 32'h0);
        rd_chk("R8 idle low-level lines not pending", 12'h200, 32'h0);
        fwd_chk("R1 no offer at reset", 1'b0, 0, 0, 0);
    endtask

    task automatic t_enable();
        wr(12'h100, 32'h0000_00F0);
        rd_chk("R3 set-enable read", 12'h100, 32'h0000_00F0);
        rd_chk("R3 clear-enable read", 12'h180, 32'h0000_00F0);
        wr(12'h180, 32'h0000_0030);
        rd_chk("R3 w1c", 12'h100, 32'h0000_00C0);
        wr(12'h100, 32'h0);
        rd_chk("R3 zero bits no effect", 12'h100, 32'h0000_00C0);
        wr(12'h104, 32'h0000_0020);
        rd_chk("R3 second word", 12'h104, 32'h0000_0020);
    endtask

    task automatic t_bytes();
        wr(12'h404, 32'h4433_2211);
        rd_chk("R5 priority bytes", 12'h404, 32'h4433_2211);
        wr(12'h808, 32'h0000_0A05);
        rd_chk("R5 target bytes", 12'h808, 32'h0000_0A05);
    endtask

    task automatic t_level();
        wr(12'hC00, 32'h0000_0040);
        rd_chk("R6 config readback", 12'hC00, 32'h0000_0040);
        settle(3);
        rd_chk("R8 level-high line 3 asserted", 12'h200, 32'h0000_0008);
        @(negedge clk); irq_in[3] = 1'b0;
        settle(3);
        rd_chk("R8 level-high line 3 released", 12'h200, 32'h0);
        @(negedge clk); irq_in[2] = 1'b0;
        settle(3);
        rd_chk("R8 default level-low line 2", 12'h280, 32'h0000_0004);
        @(negedge clk); irq_in[2] = 1'b1;
        settle(3);
        rd_chk("R8 line 2 released", 12'h200, 32'h0);
    endtask

    task automatic t_select();
        wr(12'h180, 32'hFFFF_FFFF);
        wr(12'h184, 32'hFFFF_FFFF);
        wr(12'h100, 32'h0000_0300);
        wr(12'h200, 32'h0000_0300);
        rd_chk("R4 set-pending", 12'h200, 32'h0000_0300);
        wr(12'h408, 32'h0000_3030);
        wr(12'h080, 32'h0000_0100);
        rd_chk("R12 group readback", 12'h080, 32'h0000_0100);
        settle(2);
        fwd_chk("R1 forwarding off", 1'b0, 0, 0, 0);
        wr(12'h000, 32'h1);
        rd_chk("R1 ctrl readback", 12'h000, 32'h1);
        fwd_chk("R9 tie to lower id, R12 group ignored", 1'b1, 10'd8, 8'h30, 8'h05);
        wr(12'h408, 32'h0000_2030);
        settle(1);
        fwd_chk("R9 lower value wins", 1'b1, 10'd9, 8'h20, 8'h0A);
        wr(12'h280, 32'h0000_0200);
        settle(1);
        fwd_chk("R4 clear-pending drops line 9", 1'b1, 10'd8, 8'h30, 8'h05);
        wr(12'h428, 32'h0000_0010);
        wr(12'h204, 32'h0000_0100);
        wr(12'h104, 32'h0000_0100);
        settle(1);
        fwd_chk("R9 line 40 in word 1", 1'b1, 10'd40, 8'h10, 8'h00);
        wr(12'h184, 32'h0000_0100);
        settle(1);
        fwd_chk("R3 disabled line not offered", 1'b1, 10'd8, 8'h30, 8'h05);
        wr(12'h000, 32'h0);
        settle(1);
        fwd_chk("R1 switch off stops offer", 1'b0, 0, 0, 0);
        wr(12'h000, 32'h1);
        settle(1);
        fwd_chk("R1 switch on again", 1'b1, 10'd8, 8'h30, 8'h05);
    endtask

    task automatic t_ack();
        pulse_ack();
        fwd_chk("R10 offer drops after ack", 1'b0, 0, 0, 0);
        rd_chk("R10 active bit set", 12'h380, 32'h0000_0100);
        rd_chk("R10 latched pending cleared", 12'h200, 32'h0);
        wr(12'h200, 32'h0000_0100);
        settle(2);
        fwd_chk("R10 active line withheld", 1'b0, 0, 0, 0);
        pulse_eoi(10'd8);
        settle(1);
        fwd_chk("R11 eoi re-allows line", 1'b1, 10'd8, 8'h30, 8'h05);
        pulse_ack();
        rd_chk("R10 active again", 12'h380, 32'h0000_0100);
        wr(12'h380, 32'h0000_0100);
        rd_chk("R11 w1c active", 12'h380, 32'h0);
    endtask

    task automatic t_edge();
        wr(12'hC04, 32'h0000_0300);
        rd_chk("R6 edge-high field line 20", 12'hC04, 32'h0000_0300);
        @(negedge clk); irq_in[20] = 1'b0;
        settle(3);
        rd_chk("R7 no edge yet", 12'h200, 32'h0);
        @(negedge clk); irq_in[20] = 1'b1;
        settle(3);
        rd_chk("R7 rising edge latched", 12'h200, 32'h0010_0000);
        @(negedge clk); irq_in[20] = 1'b0;
        settle(3);
        rd_chk("R7 latch holds after release", 12'h200, 32'h0010_0000);
        wr(12'h100, 32'h0010_0000);
        settle(1);
        fwd_chk("R9 edge line priority 0 wins", 1'b1, 10'd20, 8'h00, 8'h00);
        wr(12'h280, 32'h0010_0000);
        rd_chk("R7 clear latch", 12'h200, 32'h0);
    endtask

    task automatic t_unmapped();
        wr(12'h108, 32'hFFFF_FFFF);
        rd_chk("R13 beyond lines reads 0", 12'h108, 32'h0);
        rd_chk("R13 word 1 untouched", 12'h104, 32'h0);
        rd_chk("R13 hole reads 0", 12'h300, 32'h0);
        wr(12'h102, 32'hFFFF_FFFF);
        rd_chk("R13 unaligned write ignored", 12'h100, 32'h0010_0300);
        rd_chk("R13 unaligned read 0", 12'h101, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        irq_in = '1; cpu_ack = 1'b0; eoi_valid = 1'b0; eoi_id = '0;
        settle(4);
        rst = 1'b0;
        settle(3);
        t_reset();
        t_enable();
        t_bytes();
        t_level();
        t_select();
        t_ack();
        t_edge();
        t_unmapped();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule